// File: doc/BRIEF.md
# Embedded Core Test Collar

This block sits between a host chip and one embedded core and gives test access to every core terminal. Each core input terminal and each core output terminal has its own wrapper cell. Every cell holds a shift stage and an update stage. All cells are linked into one serial chain, which an outside controller loads and unloads through a single scan input and a single scan output.

A two-bit mode input selects one of three operations. In functional operation the collar is transparent. In external test it checks the interconnect around the core: the input-side cells observe the values arriving from the host, and the output-side cells drive the host from their update stages. In internal test the roles swap: the input-side cells drive the core from their update stages, and the output-side cells observe the core's response.

The shift, capture and update strobes are synchronous to the test clock. The controller sequences them the same way a boundary scan controller does.

Top module: `core_wrap`

## Requirements
- R1: When the mode is 2'b00, or the unused code 2'b11, `core_in` equals `host_in` and `host_out` equals `core_out`.
- R2: When the mode is 2'b01 (external test), `host_out` shows the update stage of the output cells, and `core_in` keeps following `host_in`.
- R3: A capture in external test loads `host_in` into the input cells and leaves the output cells unchanged.
- R4: When the mode is 2'b10 (internal test), `core_in` shows the update stage of the input cells, and `host_out` keeps following `core_out`.
- R5: A capture in internal test loads `core_out` into the output cells and leaves the input cells unchanged.
- R6: A capture in functional mode samples `host_in` into the input cells and `core_out` into the output cells.
- R7: Each shift cycle moves the chain by one position. The chain runs from `scan_in` into input cell 0, up through input cell N_IN-1, then through output cells 0 to N_OUT-1. `scan_out` is the shift stage of the last output cell.
- R8: Update copies every shift stage into its update stage. Shifting or capturing without an update leaves the values driven from the update stages unchanged.
- R9: When capture and shift are both asserted in one cycle, the capture takes effect and no shift occurs.
- R10: When update and shift are asserted in one cycle, the update stage takes the chain contents from before that cycle's shift.
- R11: Reset clears every shift stage and every update stage to zero.

Parameters: `N_IN` is the number of core input terminals and `N_OUT` is the number of core output terminals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 functional, 01 external test, 10 internal test, 11 functional |
| host_in | input | N_IN | Functional signals from the host toward the core |
| core_in | output | N_IN | Signals driven onto the core input terminals |
| core_out | input | N_OUT | Signals from the core output terminals |
| host_out | output | N_OUT | Signals driven back to the host |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output |
| shift_en | input | 1 | Shift the chain by one cell |
| capture_en | input | 1 | Load observed values into the shift stages |
| update_en | input | 1 | Copy the shift stages into the update stages |

## Verification
Two overlaps are provoked on purpose. The first is capture and shift in the same cycle: the bench unloads the chain afterwards and expects the captured pattern with nothing shifted in from `scan_in`. The second is update and shift in the same cycle: the bench expects the driven pins to show the pre-shift word on the following cycle. A reference model of the chain and the update stages, written from the requirements, predicts `scan_out`, `core_in` and `host_out` on every cycle. The bench queues these predictions and compares them with the outputs.

// File: rtl/core_wrap.sv
module core_wrap #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [N_IN-1:0]  host_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] host_out,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic             shift_en,
  input  logic             capture_en,
  input  logic             update_en
);
  localparam int L = N_IN + N_OUT;
  localparam logic [1:0] M_EXT = 2'b01;
  localparam logic [1:0] M_INT = 2'b10;

  logic ext_m, int_m;
  logic [L-1:0] chain_q, upd_q, cap_val, chain_d;

  assign ext_m = (mode == M_EXT);
  assign int_m = (mode == M_INT);

  assign cap_val[N_IN-1:0] = int_m ? chain_q[N_IN-1:0] : host_in;
  assign cap_val[L-1:N_IN] = ext_m ? chain_q[L-1:N_IN] : core_out;

  always_comb begin
    if (capture_en)    chain_d = cap_val;
    else if (shift_en) chain_d = {chain_q[L-2:0], scan_in};
    else               chain_d = chain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      upd_q   <= '0;
    end else begin
      chain_q <= chain_d;
      if (update_en) upd_q <= chain_q;
    end
  end

  assign scan_out = chain_q[L-1];
  assign core_in  = int_m ? upd_q[N_IN-1:0] : host_in;
  assign host_out = ext_m ? upd_q[L-1:N_IN] : core_out;
endmodule

module core_wrap_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            mode,
  input logic [N_IN-1:0]       host_in,
  input logic [N_IN-1:0]       core_in,
  input logic [N_OUT-1:0]      core_out,
  input logic [N_OUT-1:0]      host_out,
  input logic                  scan_in,
  input logic                  shift_en,
  input logic                  capture_en,
  input logic                  update_en,
  input logic [N_IN+N_OUT-1:0] chain_q,
  input logic [N_IN+N_OUT-1:0] upd_q
);
  localparam int L = N_IN + N_OUT;

  AST_FUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |-> (core_in == host_in && host_out == core_out)); // R1
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) == 2'b01 && !$past(update_en)) |-> $stable(host_out)); // R2
  AST_EXT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && mode == 2'b01) |=> (chain_q[N_IN-1:0] == $past(host_in)
      && chain_q[L-1:N_IN] == $past(chain_q[L-1:N_IN]))); // R3
  AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) == 2'b10 && !$past(update_en)) |-> $stable(core_in)); // R4
  AST_INT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && mode == 2'b10) |=> (chain_q[L-1:N_IN] == $past(core_out)
      && chain_q[N_IN-1:0] == $past(chain_q[N_IN-1:0]))); // R5
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !capture_en) |=> chain_q[0] == $past(scan_in)); // R7
  AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !capture_en) |=> $stable(chain_q)); // R7
  AST_UPDATE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> upd_q == $past(chain_q)); // R8
  AST_UPDATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(upd_q)); // R8
endmodule

bind core_wrap core_wrap_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .host_in(host_in), .core_in(core_in),
  .core_out(core_out), .host_out(host_out), .scan_in(scan_in),
  .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en),
  .chain_q(chain_q), .upd_q(upd_q)
);

// File: tb/core_wrap_test.sv
module core_wrap_test;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int L  = NI + NO;

  typedef struct {
    string      req;
    int         kind;
    logic [7:0] exp;
  } item_t;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] mode = 2'b00;
  logic [NI-1:0] host_in = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out;
  logic [NO-1:0] host_out;
  logic scan_in = 0, scan_out;
  logic shift_en = 0, capture_en = 0, update_en = 0;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;
  item_t sb[$];
  logic [L-1:0] m_sr = '0, m_upd = '0;

  always #4 clk = ~clk;

  function automatic logic [NO-1:0] stub(input logic [NI-1:0] c);
    return {|c, c[2] & c[3], c[0] ^ c[1]};
  endfunction

  assign core_out = stub(core_in);

  core_wrap #(.N_IN(NI), .N_OUT(NO)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .host_in(host_in), .core_in(core_in),
    .core_out(core_out), .host_out(host_out), .scan_in(scan_in), .scan_out(scan_out),
    .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en)
  );

  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = {7'd0, scan_out};
          1: act = {4'd0, core_in};
          default: act = {5'd0, host_out};
        endcase
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h at %0t", it.req, it.kind, act, it.exp, $time);
        end
      end
    end
  end

  task automatic cycle(input logic [1:0] m, input logic [NI-1:0] hi,
                       input logic sh, input logic cap, input logic up,
                       input logic si, input string req);
    logic [NI-1:0] ci_e;
    logic [NO-1:0] co_e, ho_e;
    logic [L-1:0] nsr;
    @(negedge clk);
    mode = m; host_in = hi; shift_en = sh; capture_en = cap; update_en = up; scan_in = si;
    ci_e = (m == 2'b10) ? m_upd[NI-1:0] : hi;
    co_e = stub(ci_e);
    ho_e = (m == 2'b01) ? m_upd[L-1:NI] : co_e;
    sb.push_back('{req, 0, {7'd0, m_sr[L-1]}});
    sb.push_back('{req, 1, {4'd0, ci_e}});
    sb.push_back('{req, 2, {5'd0, ho_e}});
    nsr = m_sr;
    if (cap) begin
      if (m != 2'b10) nsr[NI-1:0] = hi;
      if (m != 2'b01) nsr[L-1:NI] = co_e;
    end else if (sh) begin
      nsr = {m_sr[L-2:0], si};
    end
    if (up) m_upd = m_sr;
    m_sr = nsr;
  endtask

  task automatic shift_word(input logic [1:0] m, input logic [NI-1:0] hi,
                            input logic [L-1:0] v, input string req);
    for (int i = L - 1; i >= 0; i--) cycle(m, hi, 1'b1, 1'b0, 1'b0, v[i], req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cycle(2'b00, 4'h5, 0, 0, 0, 0, "R11");
    cycle(2'b11, 4'hA, 0, 0, 0, 0, "R1");
    shift_word(2'b01, 4'h3, 7'b1010110, "R7");
    cycle(2'b01, 4'h3, 0, 0, 1, 0, "R8");
    cycle(2'b01, 4'hC, 0, 0, 0, 0, "R2");
    cycle(2'b01, 4'h9, 0, 1, 0, 0, "R3");
    shift_word(2'b01, 4'h9, 7'b0, "R3");
    shift_word(2'b10, 4'h0, 7'b0110011, "R7");
    cycle(2'b10, 4'h0, 0, 0, 1, 0, "R8");
    cycle(2'b10, 4'hF, 0, 0, 0, 0, "R4");
    cycle(2'b10, 4'hF, 0, 1, 0, 0, "R5");
    shift_word(2'b10, 4'hF, 7'b1111111, "R5");
    cycle(2'b00, 4'h6, 0, 1, 0, 0, "R6");
    shift_word(2'b00, 4'h6, 7'b1111111, "R6");
    cycle(2'b01, 4'h2, 1, 1, 0, 1, "R9");
    shift_word(2'b01, 4'h2, 7'b0, "R9");
    shift_word(2'b00, 4'h0, 7'b1100101, "R7");
    cycle(2'b01, 4'h0, 1, 0, 1, 0, "R10");
    cycle(2'b01, 4'h0, 0, 0, 0, 0, "R10");
    cycle(2'b10, 4'h0, 0, 0, 0, 0, "R10");
    cycle(2'b00, 4'h7, 0, 0, 0, 0, "R1");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule